// File: doc/BRIEF.md
# Programmable SPI Serial Clock Phase Generator

This block derives a serial clock for an SPI controller from a fast input clock. A single 32-bit clock register holds three 6-bit counts and a clock source flag. The low field (bits 5:0) is the period count, the middle field (bits 11:6) is the high-phase count, and the field at bits 17:12 is the divider value. Only the period and high-phase counts shape the waveform. The other fields are stored and read back for the neighbouring logic.

While the transfer engine holds the enable high, the generator drives a clock of programmable period and high time. Because the high time is set separately from the period, odd divisors still come out close to 50% duty cycle. Together with the clock it emits two one-cycle strobes:
- a sample strobe for each rising edge;
- a shift strobe for each falling edge.

Dropping the enable returns the clock to its low idle level at once. The next enable starts again from a full low phase.

Top module: `spiclk_phase_gen`

## Requirements
- R1: After reset, `sck`, `sample_stb` and `shift_stb` are 0, and `cfg_rdata` reads 0.
- R2: A write with `cfg_we` stores bits 31 and 17:0 of `cfg_wdata`. From the next cycle `cfg_rdata` returns them, with every other bit reading 0. For example, writing 0xFFFFFFFF reads back as 0x8003FFFF.
- R3: While `gen_en` is low, `sck`, `sample_stb` and `shift_stb` stay 0, even when the register is written.
- R4: After `gen_en` rises, `sck` first rises after a full low phase of L cycles.
  - The effective period count is pe = max(per, 1), where per is bits 5:0.
  - The effective high count is he = min(hi, pe-1), where hi is bits 11:6.
  - L = pe - he.
  - `sck` is first high in the L-th cycle after the first clock edge at which `gen_en` is sampled high.
- R5: While enabled, one `sck` period lasts pe+1 input cycles, and this repeats for as long as `gen_en` stays high.
- R6: `sck` is high for he+1 cycles and low for L cycles, so the low phase always lasts at least one cycle. This holds for any hi, including hi ≥ pe.
- R7: `sample_stb` is 1 exactly in the first cycle in which `sck` is high, and `shift_stb` is 1 exactly in the first low cycle after a high phase. The two strobes are never 1 together.
- R8: A period count of 0 behaves as 1, giving `sck` at the input clock divided by 2 with one high and one low cycle.
- R9: Dropping `gen_en` in the middle of a phase forces `sck` and both strobes to 0 from the next cycle. A later enable restarts with a full low phase, as in R4.
- R10: The source bit (31) and the divider field (17:12) have no effect on the `sck` waveform or the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write strobe for the clock register |
| cfg_wdata | input | 32 | Clock register write data |
| cfg_rdata | output | 32 | Stored clock register value |
| gen_en | input | 1 | Generator enable from the transfer engine |
| sck | output | 1 | Serial clock |
| sample_stb | output | 1 | One-cycle pulse in the first high cycle of `sck` |
| shift_stb | output | 1 | One-cycle pulse in the first low cycle after a high phase |

## Verification
The waveform is checked cycle by cycle against the expected phase pattern under a range of settings:
- Random period and high counts cover both balanced and skewed duty cycles.
- Directed settings cover the divide-by-2 limit, the maximal period and a high count that needs clamping, which separates the clamp from plain truncation.
- Pairs of settings that differ only in the source and divider fields show those fields are inert.

An enable dropped during a high phase, and a register write made while the generator is disabled, show the idle forcing and the restart from a full low phase.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
  localparam int REG_W   = 32;
  localparam int CNT_W   = 6;
  localparam int PER_LSB = 0;
  localparam int HI_LSB  = 6;
  localparam int DIV_LSB = 12;
  localparam int SRC_BIT = 31;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic src;
    cnt_t div;
    cnt_t hi;
    cnt_t per;
  } clk_cfg_t;

  // Effective period count: a zero count is lifted to one.
  function automatic cnt_t eff_period(cnt_t per);
    return (per == '0) ? cnt_t'(1) : per;
  endfunction

  // Effective high count: clamped so at least one low cycle remains.
  function automatic cnt_t eff_high(cnt_t per, cnt_t hi);
    cnt_t pe;
    pe = eff_period(per);
    return (hi >= pe) ? cnt_t'(pe - cnt_t'(1)) : hi;
  endfunction

  function automatic cnt_t low_cycles(cnt_t per, cnt_t hi);
    return cnt_t'(eff_period(per) - eff_high(per, hi));
  endfunction

  function automatic cnt_t high_cycles(cnt_t per, cnt_t hi);
    return cnt_t'(eff_high(per, hi) + cnt_t'(1));
  endfunction
endpackage

// File: rtl/spiclk_cfg_reg.sv
module spiclk_cfg_reg
  import spiclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output clk_cfg_t         cfg,
  output logic [REG_W-1:0] rdata
);
  clk_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.src <= wdata[SRC_BIT];
      cfg_q.div <= wdata[DIV_LSB +: CNT_W];
      cfg_q.hi  <= wdata[HI_LSB  +: CNT_W];
      cfg_q.per <= wdata[PER_LSB +: CNT_W];
    end
  end

  always_comb begin
    rdata                    = '0;
    rdata[SRC_BIT]           = cfg_q.src;
    rdata[DIV_LSB +: CNT_W]  = cfg_q.div;
    rdata[HI_LSB  +: CNT_W]  = cfg_q.hi;
    rdata[PER_LSB +: CNT_W]  = cfg_q.per;
  end

  assign cfg = cfg_q;

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[3*CNT_W-1:0] == $past(wdata[3*CNT_W-1:0])) &&
              (rdata[SRC_BIT] == $past(wdata[SRC_BIT])));
endmodule

// File: rtl/spiclk_len_calc.sv
module spiclk_len_calc
  import spiclk_pkg::*;
(
  input  clk_cfg_t cfg,
  output cnt_t     low_len,
  output cnt_t     high_len
);
  // Only the period and high counts shape the waveform.
  assign low_len  = low_cycles(cfg.per, cfg.hi);
  assign high_len = high_cycles(cfg.per, cfg.hi);
endmodule

// File: rtl/spiclk_phase.sv
module spiclk_phase
  import spiclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  cnt_t low_len,
  input  cnt_t high_len,
  output logic sck,
  output logic sample_stb,
  output logic shift_stb
);
  cnt_t cnt_q;
  logic sck_q, smp_q, sft_q;
  cnt_t cur_len;
  logic phase_end;

  assign cur_len   = sck_q ? high_len : low_len;
  // >= keeps a mid-phase shortening of the counts from overrunning.
  assign phase_end = (cnt_q >= cnt_t'(cur_len - cnt_t'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
      smp_q <= 1'b0;
      sft_q <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
      smp_q <= 1'b0;
      sft_q <= 1'b0;
    end else if (phase_end) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
      smp_q <= ~sck_q;
      sft_q <= sck_q;
    end else begin
      cnt_q <= cnt_q + cnt_t'(1);
      smp_q <= 1'b0;
      sft_q <= 1'b0;
    end
  end

  assign sck        = sck_q;
  assign sample_stb = smp_q;
  assign shift_stb  = sft_q;

  assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sck_q && !smp_q && !sft_q));
  assert_sample_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_q) |-> smp_q);
  assert_shift_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sft_q |-> (!sck_q && $past(sck_q)));
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smp_q, sft_q}));
endmodule

// File: rtl/spiclk_phase_gen.sv
module spiclk_phase_gen
  import spiclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             gen_en,
  output logic             sck,
  output logic             sample_stb,
  output logic             shift_stb
);
  clk_cfg_t cfg;
  cnt_t     low_len;
  cnt_t     high_len;

  spiclk_cfg_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rdata(cfg_rdata)
  );

  spiclk_len_calc u_len (
    .cfg(cfg), .low_len(low_len), .high_len(high_len)
  );

  spiclk_phase u_phase (
    .clk(clk), .rst_n(rst_n), .en(gen_en),
    .low_len(low_len), .high_len(high_len),
    .sck(sck), .sample_stb(sample_stb), .shift_stb(shift_stb)
  );
endmodule

// File: tb/spiclk_phase_gen_tb_top.sv
module spiclk_phase_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        gen_en = 1'b0;
  logic        sck, sample_stb, shift_stb;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  spiclk_phase_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .gen_en(gen_en), .sck(sck),
    .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  function automatic int bpe(int p);
    return (p == 0) ? 1 : p;
  endfunction
  function automatic int bhe(int p, int h);
    return (h >= bpe(p)) ? bpe(p) - 1 : h;
  endfunction
  function automatic int blow(int p, int h);
    return bpe(p) - bhe(p, h);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(int p, int h, int d, bit s);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {s, 13'd0, d[5:0], h[5:0], p[5:0]};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Enable and compare every cycle with the expected pattern.
  task automatic run_wave(int p, int h, string tag);
    int per = bpe(p) + 1;
    int lo = blow(p, h);
    int ncyc = 3 * per + lo + 2;
    int bad_idx = -1;
    int act = 0, exp = 0;
    gen_en = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      int m = i % per;
      bit es = (m >= lo);
      bit ea = (m == lo);
      bit ef = (m == 0) && (i > 0);
      if (bad_idx < 0 && ({sck, sample_stb, shift_stb} != {es, ea, ef})) begin
        bad_idx = i;
        act = {sck, sample_stb, shift_stb};
        exp = {es, ea, ef};
      end
      @(negedge clk);
    end
    gen_en = 1'b0;
    @(negedge clk);
    if (bad_idx >= 0)
      $display("FAIL detail %s per=%0d hi=%0d at cycle %0d", tag, p, h, bad_idx);
    check(bad_idx < 0, tag, act, exp);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check({sck, sample_stb, shift_stb} == 3'b000, "R1 outputs after reset", int'({sck, sample_stb, shift_stb}), 0);
    check(cfg_rdata == 32'd0, "R1 rdata after reset", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    write_cfg(63, 63, 63, 1'b1);
    check(cfg_rdata == 32'h8003FFFF, "R2 store mask", int'(cfg_rdata), int'(32'h8003FFFF));
    write_cfg(5, 2, 9, 1'b0);
    check(cfg_rdata == 32'h0000_9085, "R2 field positions", int'(cfg_rdata), int'(32'h9085));

    begin : idle_chk
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        if (i == 7) begin cfg_we = 1'b1; cfg_wdata = 32'h0000_0041; end
        if (i == 8) cfg_we = 1'b0;
        seen |= {sck, sample_stb, shift_stb};
        @(negedge clk);
      end
      check(seen == 0, "R3 idle while disabled", seen, 0);
    end

    write_cfg(4, 1, 0, 1'b0);  run_wave(4, 1, "R4 R5 R6 R7 per4 hi1");
    write_cfg(5, 2, 0, 1'b0);  run_wave(5, 2, "R6 odd divisor per5 hi2");
    write_cfg(0, 0, 0, 1'b0);  run_wave(0, 0, "R8 zero period");
    write_cfg(1, 0, 0, 1'b0);  run_wave(1, 0, "R8 period one");
    write_cfg(0, 5, 0, 1'b0);  run_wave(0, 5, "R8 R6 zero period clamp");
    write_cfg(63, 63, 0, 1'b0); run_wave(63, 63, "R5 R6 max period clamp");
    write_cfg(10, 40, 0, 1'b0); run_wave(10, 40, "R6 clamp hi above per");
    write_cfg(9, 4, 0, 1'b0);  run_wave(9, 4, "R10 base");
    write_cfg(9, 4, 63, 1'b1); run_wave(9, 4, "R10 src and div set");

    // R9: drop enable during the high phase, then restart.
    write_cfg(6, 3, 0, 1'b0);
    gen_en = 1'b1;
    for (int i = 0; i < blow(6, 3) + 1; i++) @(negedge clk);
    check(sck == 1'b1, "R9 high before drop", int'(sck), 1);
    gen_en = 1'b0;
    @(negedge clk);
    check({sck, sample_stb, shift_stb} == 3'b000, "R9 forced idle", int'({sck, sample_stb, shift_stb}), 0);
    run_wave(6, 3, "R9 restart full low");

    for (int k = 0; k < 20; k++) begin
      int p = int'($urandom_range(63, 0));
      int h = int'($urandom_range(63, 0));
      int d = int'($urandom_range(63, 0));
      bit s = bit'($urandom_range(1, 0));
      write_cfg(p, h, d, s);
      run_wave(p, h, "R5 R6 R7 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule